// File: doc/BRIEF.md
# Firmware Image Transfer Sequencer

This block runs the host side of a firmware download to a system controller. The image moves through a shared staging window. The two sides coordinate through a three-word mailbox that holds a status word, a controller flag and a host flag. On a start pulse the sequencer does the following, in order:

- sends a "get ready" command word;
- clears the mailbox;
- asks an external copy engine to stage the image header;
- sends a "go" command word.

It then moves the image body in two large chunks per pass, a low half and a high half. The two sides take turns through the flags, and ASCII status words from the controller gate each half.

When the controller answers a high half with the low-half code again, the sequencer starts the pass again from the low-half chunk. A counter bounds these repeats. Every mailbox poll has a programmable cycle timeout. The run ends with a one-cycle finish pulse and a pass/fail level.

The host drives three outbound channels, and each one carries its own handshake:
- Commands and mailbox writes use valid/ready. Valid may rise at any time. Valid and payload then hold until the cycle in which ready is high, and that cycle is the transfer. The block never drops valid without a transfer.
- The copy engine receives a one-cycle start pulse with source offset and byte length. It answers with a one-cycle done pulse.

Top module: `fwx_xfer_seq`

## Requirements
- R1: Out of reset the block is idle: busy, fin, cmd_valid, mw_valid and cp_start are low. A start pulse while idle issues command word 0x10FE on the command channel.
- R2: After the ready command transfers, the block issues three mailbox writes of value 0, in this order: select 0 (status), select 1 (controller flag), select 2 (host flag).
- R3: It then requests a copy with source 0 and length 0x800. After copy-done it issues command 0x20FE. While a copy is outstanding, neither cmd_valid nor mw_valid is asserted.
- R4: After the go command, it waits for controller flag == 1 and then for status == 0x54784C4F (low half). It then requests a copy with source 0x800 and length 0x20000, and after copy-done writes host flag (select 2) = 1.
- R5: It then waits for controller flag != 1. If status == 0x4241444E (bad storage), it finishes with failure. Otherwise it waits for status == 0x54784849 (high half), copies source 0x20800 with length 0x20000, and writes host flag = 0.
- R6: It then waits for controller flag != 0. Bad storage finishes with failure. A status of 0x54784C4F starts the pass again with the low-half copy at source 0x800. Any other status finishes.
- R7: Each repeat increments a retry count. Once that count exceeds 5, the block finishes with failure and issues no further copy, so a run has at most six low-half copies.
- R8: Finishing raises fin for exactly one cycle and returns the block to idle. pass is 1 only when status equals 0x444F4E45 (done) at that point.
- R9: A mailbox poll not met within tmo_cycles cycles finishes the run with failure, about tmo_cycles + 2 cycles after the wait began.
- R10: Once cmd_valid or mw_valid is high without ready, it stays high with unchanged payload in the next cycle.
- R11: cp_start is a single-cycle pulse. A start pulse while busy has no effect on the command, mailbox or copy traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (honoured only when idle) |
| tmo_cycles | input | TMO_W | Poll timeout in cycles |
| busy | output | 1 | Sequence in progress |
| fin | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the run, valid with fin |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Command channel accepts |
| cmd_word | output | 16 | Command word |
| mw_valid | output | 1 | Mailbox write valid |
| mw_ready | input | 1 | Mailbox write accepted |
| mw_sel | output | 2 | Mailbox word: 0 status, 1 controller flag, 2 host flag |
| mw_data | output | 32 | Mailbox write value |
| mb_status | input | 32 | Mailbox status word as read |
| mb_cflag | input | 32 | Mailbox controller flag as read |
| cp_start | output | 1 | Copy request pulse |
| cp_src | output | OFF_W | Copy source byte offset in the image |
| cp_len | output | OFF_W | Copy length in bytes |
| cp_done | input | 1 | Copy engine completion pulse |

## Verification
Command and mailbox transfers count in the cycle where valid and ready are both high. The bench samples each channel half a cycle before that edge and compares it in order against a queue of expected transfers, so back-pressure delays a result without changing what is expected. A copy request shows on cp_start in the cycle after the state that issues it is entered. The next mailbox write can appear one edge after cp_done is seen, and the bench flags any valid seen while its copy model still has done pending. fin rises two edges after the poll condition or the timeout expiry that ends the run. The timeout check therefore accepts a finish between tmo_cycles and tmo_cycles + 4 samples after the go command transfers.

// File: rtl/fwx_pkg.sv
`timescale 1ns/1ps
package fwx_pkg;
  localparam int MB_W = 32;

  localparam logic [15:0] CMD_READY = 16'h10FE;
  localparam logic [15:0] CMD_GO    = 16'h20FE;

  localparam logic [MB_W-1:0] ST_DONE = 32'h444F4E45;
  localparam logic [MB_W-1:0] ST_BAD  = 32'h4241444E;
  localparam logic [MB_W-1:0] ST_LOW  = 32'h54784C4F;
  localparam logic [MB_W-1:0] ST_HIGH = 32'h54784849;

  localparam logic [1:0] MB_STATUS = 2'd0;
  localparam logic [1:0] MB_CFLAG  = 2'd1;
  localparam logic [1:0] MB_HFLAG  = 2'd2;

  typedef enum logic [4:0] {
    S_IDLE, S_CMD_RDY, S_CLR, S_HDR_REQ, S_HDR_WAIT, S_CMD_GO,
    S_P_CF1, S_P_LOW, S_LO_CHK, S_LO_REQ, S_LO_WAIT, S_HF1,
    S_P_CFN1, S_P_HIGH, S_HI_REQ, S_HI_WAIT, S_HF0, S_P_CFNZ, S_FIN
  } fwx_state_e;
endpackage

// File: rtl/fwx_poll_timer.sv
`timescale 1ns/1ps
module fwx_poll_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_en,
  input  logic             hit,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!poll_en || hit)  cnt <= '0;
    else if (cnt != '1)        cnt <= cnt + 1'b1;
  end

  assign expired = poll_en && !hit && (cnt >= limit);
endmodule

// File: rtl/fwx_chunk_track.sv
`timescale 1ns/1ps
module fwx_chunk_track #(
  parameter int OFF_W       = 32,
  parameter int CHUNK_BYTES = 32'h20000,
  parameter int MAX_RETRY   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_clr,
  input  logic             adv,
  input  logic [OFF_W-1:0] adv_len,
  input  logic             rewind,
  output logic [OFF_W-1:0] off,
  output logic             retry_over
);
  localparam int RC_W = $clog2(MAX_RETRY + 2);
  localparam logic [OFF_W-1:0] BACK = OFF_W'(2 * CHUNK_BYTES);
  localparam logic [RC_W-1:0] RC_LIM = RC_W'(MAX_RETRY);

  logic [RC_W-1:0] rc;

  always_ff @(posedge clk) begin
    if (!rst_n || seq_clr) begin
      off <= '0;
      rc  <= '0;
    end else if (adv) begin
      off <= off + adv_len;
    end else if (rewind) begin
      off <= off - BACK;
      if (rc <= RC_LIM) rc <= rc + 1'b1;
    end
  end

  assign retry_over = (rc > RC_LIM);
endmodule

// File: rtl/fwx_ctrl.sv
`timescale 1ns/1ps
module fwx_ctrl
  import fwx_pkg::*;
#(
  parameter int OFF_W       = 32,
  parameter int HDR_BYTES   = 2048,
  parameter int CHUNK_BYTES = 32'h20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             fin,
  output logic             pass,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [15:0]      cmd_word,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [1:0]       mw_sel,
  output logic [MB_W-1:0]  mw_data,
  input  logic [MB_W-1:0]  mb_status,
  input  logic [MB_W-1:0]  mb_cflag,
  output logic             cp_start,
  output logic [OFF_W-1:0] cp_len,
  input  logic             cp_done,
  output logic             poll_en,
  output logic             poll_hit,
  input  logic             tmo_exp,
  output logic             seq_clr,
  output logic             adv,
  output logic             rewind,
  input  logic             retry_over
);
  fwx_state_e state, nxt;
  logic [1:0] clr_idx;
  logic       pass_q;

  always_comb begin
    poll_en  = 1'b1;
    poll_hit = 1'b0;
    unique case (state)
      S_P_CF1:  poll_hit = (mb_cflag == 32'd1);
      S_P_LOW:  poll_hit = (mb_status == ST_LOW);
      S_P_CFN1: poll_hit = (mb_cflag != 32'd1);
      S_P_HIGH: poll_hit = (mb_status == ST_HIGH);
      S_P_CFNZ: poll_hit = (mb_cflag != 32'd0);
      default:  poll_en  = 1'b0;
    endcase
  end

  always_comb begin
    nxt    = state;
    rewind = 1'b0;
    unique case (state)
      S_IDLE:     if (start) nxt = S_CMD_RDY;
      S_CMD_RDY:  if (cmd_ready) nxt = S_CLR;
      S_CLR:      if (mw_ready && clr_idx == MB_HFLAG) nxt = S_HDR_REQ;
      S_HDR_REQ:  nxt = S_HDR_WAIT;
      S_HDR_WAIT: if (cp_done) nxt = S_CMD_GO;
      S_CMD_GO:   if (cmd_ready) nxt = S_P_CF1;
      S_P_CF1:    if (poll_hit) nxt = S_P_LOW;
      S_P_LOW:    if (poll_hit) nxt = S_LO_CHK;
      S_LO_CHK:   nxt = retry_over ? S_FIN : S_LO_REQ;
      S_LO_REQ:   nxt = S_LO_WAIT;
      S_LO_WAIT:  if (cp_done) nxt = S_HF1;
      S_HF1:      if (mw_ready) nxt = S_P_CFN1;
      S_P_CFN1:   if (poll_hit) nxt = (mb_status == ST_BAD) ? S_FIN : S_P_HIGH;
      S_P_HIGH:   if (poll_hit) nxt = S_HI_REQ;
      S_HI_REQ:   nxt = S_HI_WAIT;
      S_HI_WAIT:  if (cp_done) nxt = S_HF0;
      S_HF0:      if (mw_ready) nxt = S_P_CFNZ;
      S_P_CFNZ:   if (poll_hit) begin
                    if (mb_status == ST_LOW) begin
                      rewind = 1'b1;
                      nxt    = S_LO_CHK;
                    end else begin
                      nxt = S_FIN;
                    end
                  end
      S_FIN:      nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
    if (poll_en && tmo_exp) nxt = S_FIN;
  end

  assign seq_clr = (state == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      clr_idx <= MB_STATUS;
      pass_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (seq_clr) begin
        clr_idx <= MB_STATUS;
        pass_q  <= 1'b0;
      end else begin
        if (state == S_CLR && mw_ready) clr_idx <= clr_idx + 2'd1;
        if (nxt == S_FIN) pass_q <= (mb_status == ST_DONE) && !tmo_exp;
      end
    end
  end

  assign busy      = (state != S_IDLE);
  assign fin       = (state == S_FIN);
  assign pass      = pass_q;
  assign cmd_valid = (state == S_CMD_RDY) || (state == S_CMD_GO);
  assign cmd_word  = (state == S_CMD_GO) ? CMD_GO : CMD_READY;
  assign mw_valid  = (state == S_CLR) || (state == S_HF1) || (state == S_HF0);
  assign mw_sel    = (state == S_CLR) ? clr_idx : MB_HFLAG;
  assign mw_data   = (state == S_HF1) ? 32'd1 : 32'd0;
  assign cp_start  = (state == S_HDR_REQ) || (state == S_LO_REQ) || (state == S_HI_REQ);
  assign cp_len    = (state == S_HDR_REQ || state == S_HDR_WAIT) ? OFF_W'(HDR_BYTES)
                                                                 : OFF_W'(CHUNK_BYTES);
  assign adv       = cp_done && ((state == S_HDR_WAIT) || (state == S_LO_WAIT) ||
                                 (state == S_HI_WAIT));
endmodule

// File: rtl/fwx_xfer_seq.sv
`timescale 1ns/1ps
module fwx_xfer_seq
  import fwx_pkg::*;
#(
  parameter int OFF_W       = 32,
  parameter int TMO_W       = 20,
  parameter int HDR_BYTES   = 2048,
  parameter int CHUNK_BYTES = 32'h20000,
  parameter int MAX_RETRY   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMO_W-1:0] tmo_cycles,
  output logic             busy,
  output logic             fin,
  output logic             pass,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [15:0]      cmd_word,
  output logic             mw_valid,
  input  logic             mw_ready,
  output logic [1:0]       mw_sel,
  output logic [31:0]      mw_data,
  input  logic [31:0]      mb_status,
  input  logic [31:0]      mb_cflag,
  output logic             cp_start,
  output logic [OFF_W-1:0] cp_src,
  output logic [OFF_W-1:0] cp_len,
  input  logic             cp_done
);
  logic poll_en, poll_hit, tmo_exp;
  logic seq_clr, adv, rewind, retry_over;

  fwx_ctrl #(
    .OFF_W(OFF_W), .HDR_BYTES(HDR_BYTES), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .fin(fin), .pass(pass),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_sel(mw_sel), .mw_data(mw_data),
    .mb_status(mb_status), .mb_cflag(mb_cflag),
    .cp_start(cp_start), .cp_len(cp_len), .cp_done(cp_done),
    .poll_en(poll_en), .poll_hit(poll_hit), .tmo_exp(tmo_exp),
    .seq_clr(seq_clr), .adv(adv), .rewind(rewind), .retry_over(retry_over)
  );

  fwx_poll_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .hit(poll_hit),
    .limit(tmo_cycles), .expired(tmo_exp)
  );

  fwx_chunk_track #(
    .OFF_W(OFF_W), .CHUNK_BYTES(CHUNK_BYTES), .MAX_RETRY(MAX_RETRY)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .adv(adv), .adv_len(cp_len),
    .rewind(rewind), .off(cp_src), .retry_over(retry_over)
  );
endmodule

// File: rtl/fwx_xfer_sva.sv
`timescale 1ns/1ps
module fwx_xfer_sva #(
  parameter int OFF_W       = 32,
  parameter int HDR_BYTES   = 2048,
  parameter int CHUNK_BYTES = 32'h20000,
  parameter int MAX_RETRY   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             fin,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [15:0]      cmd_word,
  input logic             mw_valid,
  input logic             mw_ready,
  input logic [1:0]       mw_sel,
  input logic [31:0]      mw_data,
  input logic             cp_start,
  input logic [OFF_W-1:0] cp_src,
  input logic [OFF_W-1:0] cp_len,
  input logic             cp_done
);
  logic       copy_pend;
  logic [7:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copy_pend <= 1'b0;
      lo_cnt    <= '0;
    end else begin
      if (cp_start)     copy_pend <= 1'b1;
      else if (cp_done) copy_pend <= 1'b0;
      if (start && !busy) lo_cnt <= '0;
      else if (cp_start && cp_src == OFF_W'(HDR_BYTES) && cp_len == OFF_W'(CHUNK_BYTES)
               && lo_cnt != 8'hFF)
        lo_cnt <= lo_cnt + 8'd1;
    end
  end

  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));
  a_r10_mw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_sel) && $stable(mw_data));
  a_r11_cp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start |=> !cp_start);
  a_r3_quiet_copy: assert property (@(posedge clk) disable iff (!rst_n)
    copy_pend |-> !mw_valid && !cmd_valid);
  a_r4_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start |-> (cp_len == OFF_W'(HDR_BYTES)) || (cp_len == OFF_W'(CHUNK_BYTES)));
  a_r8_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin && !busy);
  a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= 8'(MAX_RETRY + 1));
endmodule

bind fwx_xfer_seq fwx_xfer_sva #(
  .OFF_W(OFF_W), .HDR_BYTES(HDR_BYTES), .CHUNK_BYTES(CHUNK_BYTES), .MAX_RETRY(MAX_RETRY)
) u_fwx_sva (.*);

// File: tb/tb_fwx_xfer_seq.sv
`timescale 1ns/1ps
module tb_fwx_xfer_seq;
  import fwx_pkg::*;
  localparam int OFF_W = 32, TMO_W = 20, MAX_RETRY = 5;
  localparam logic [31:0] HDR = 32'h800, CHUNK = 32'h20000;
  localparam int K_CMD = 0, K_MW = 1, K_CP = 2, K_FIN = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [TMO_W-1:0] tmo_cycles = '0;
  logic busy, fin, pass, cmd_valid, mw_valid, cp_start;
  logic cmd_ready = 1'b0, mw_ready = 1'b0, cp_done = 1'b0;
  logic [15:0] cmd_word;
  logic [1:0] mw_sel;
  logic [31:0] mw_data, mb_status = '0, mb_cflag = '0;
  logic [OFF_W-1:0] cp_src, cp_len;

  fwx_xfer_seq dut (.*);

  always #2 clk = ~clk;

  typedef struct { int kind; logic [31:0] a; logic [31:0] b; string req; } ev_t;
  ev_t expq[$];
  int n_chk = 0, n_fail = 0, cyc = 0, cp_timer = 0, go_cyc = 0, fin_cyc = 0;
  bit quiet_bad = 0, cmd_wait_q = 0, mw_wait_q = 0;
  logic [15:0] cmd_word_q;
  logic [1:0] mw_sel_q;
  logic [31:0] mw_data_q;
  event ev_go, ev_h1, ev_h0, ev_fin;

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic push(int k, logic [31:0] a, logic [31:0] b, string r);
    ev_t e;
    e.kind = k; e.a = a; e.b = b; e.req = r;
    expq.push_back(e);
  endtask

  task automatic observe(int k, logic [31:0] a, logic [31:0] b);
    ev_t e;
    if (expq.size() == 0) begin
      chk(0, "R11", "unexpected transfer kind", 32'(k), 32'hFFFFFFFF);
      return;
    end
    e = expq.pop_front();
    chk(e.kind == k, e.req, "transfer kind", 32'(k), 32'(e.kind));
    chk(e.a == a, e.req, "transfer field a", a, e.a);
    chk(e.b == b, e.req, "transfer field b", b, e.b);
  endtask

  // back-pressure pattern, driven away from the active edge
  always @(negedge clk) begin
    cmd_ready = (cyc % 3) != 2;
    mw_ready  = (cyc % 4) != 1;
  end

  // monitor, mailbox model and copy engine model
  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      if (cmd_wait_q)  // R10
        chk(cmd_valid && cmd_word == cmd_word_q, "R10", "command held", {16'h0, cmd_word}, {16'h0, cmd_word_q});
      if (mw_wait_q)   // R10
        chk(mw_valid && mw_sel == mw_sel_q && mw_data == mw_data_q, "R10", "mailbox write held", mw_data, mw_data_q);
      cmd_wait_q = cmd_valid && !cmd_ready; cmd_word_q = cmd_word;
      mw_wait_q = mw_valid && !mw_ready; mw_sel_q = mw_sel; mw_data_q = mw_data;
      if (cp_timer > 0 && (mw_valid || cmd_valid)) quiet_bad = 1;
      if (cmd_valid && cmd_ready) begin
        observe(K_CMD, {16'h0, cmd_word}, 32'h0);
        if (cmd_word == CMD_GO) begin go_cyc = cyc; ->ev_go; end
      end
      if (mw_valid && mw_ready) begin
        observe(K_MW, {30'h0, mw_sel}, mw_data);
        if (mw_sel == MB_STATUS) mb_status = mw_data;
        if (mw_sel == MB_CFLAG) mb_cflag = mw_data;
        if (mw_sel == MB_HFLAG) begin
          if (mw_data == 32'd1) ->ev_h1; else ->ev_h0;
        end
      end
      cp_done = 1'b0;
      if (cp_timer > 0) begin
        cp_timer--;
        if (cp_timer == 0) cp_done = 1'b1;
      end
      if (cp_start) begin
        observe(K_CP, cp_src, cp_len);
        cp_timer = 6;
      end
      if (fin) begin
        observe(K_FIN, {31'h0, pass}, 32'h0);
        fin_cyc = cyc;
        ->ev_fin;
      end
    end
  end

  // controller-side model
  task automatic ctl(int bad_at, int repeats, bit hang);
    int lows = 0;
    @(ev_go);
    if (hang) return;
    repeat (3) @(negedge clk); mb_cflag = 32'd1;
    repeat (2) @(negedge clk); mb_status = ST_LOW;
    while (1) begin
      @(ev_h1);
      repeat (4) @(negedge clk);
      if (bad_at == 1) begin mb_status = ST_BAD; mb_cflag = 32'd0; return; end
      mb_cflag = 32'd0;
      repeat (3) @(negedge clk); mb_status = ST_HIGH;
      @(ev_h0);
      repeat (4) @(negedge clk);
      if (bad_at == 2) begin mb_status = ST_BAD; mb_cflag = 32'd1; return; end
      if (lows < repeats) begin
        mb_status = ST_LOW; mb_cflag = 32'd1; lows++;
        if (lows > MAX_RETRY) return;
      end else begin
        mb_status = ST_DONE; mb_cflag = 32'd1; return;
      end
    end
  endtask

  // driver: pushes expected transfers, then runs one transfer
  task automatic run_case(int bad_at, int repeats, bit hang, int tmo, bit poke);
    int diff;
    push(K_CMD, {16'h0, CMD_READY}, 0, "R1");
    push(K_MW, MB_STATUS, 0, "R2");
    push(K_MW, MB_CFLAG, 0, "R2");
    push(K_MW, MB_HFLAG, 0, "R2");
    push(K_CP, 0, HDR, "R3");
    push(K_CMD, {16'h0, CMD_GO}, 0, "R3");
    if (hang) push(K_FIN, 0, 0, "R9");
    else begin
      for (int p = 0; ; p++) begin
        push(K_CP, HDR, CHUNK, (p == 0) ? "R4" : "R6");
        push(K_MW, MB_HFLAG, 1, "R4");
        if (bad_at == 1) begin push(K_FIN, 0, 0, "R5"); break; end
        push(K_CP, HDR + CHUNK, CHUNK, "R5");
        push(K_MW, MB_HFLAG, 0, "R5");
        if (bad_at == 2) begin push(K_FIN, 0, 0, "R6"); break; end
        if (p < repeats) begin
          if (p + 1 > MAX_RETRY) begin push(K_FIN, 0, 0, "R7"); break; end
        end else begin
          push(K_FIN, 1, 0, "R8"); break;
        end
      end
    end
    tmo_cycles = TMO_W'(tmo);
    quiet_bad = 0;
    fork ctl(bad_at, repeats, hang); join_none
    if (poke) fork begin
      repeat (30) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    end join_none
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(ev_fin);
    repeat (3) @(negedge clk);
    #1;
    chk(expq.size() == 0, "R8", "transfers still expected", 32'(expq.size()), 0);
    chk(!busy && !fin, "R8", "idle after finish", {30'h0, busy, fin}, 0);
    chk(!quiet_bad, "R3", "channel quiet during copy", {31'h0, quiet_bad}, 0);
    if (hang) begin
      diff = fin_cyc - go_cyc;
      chk(diff >= tmo && diff <= tmo + 4, "R9", "timeout latency", 32'(diff), 32'(tmo + 2));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !fin && !cmd_valid && !mw_valid && !cp_start, "R1", "reset state",
        {27'h0, busy, fin, cmd_valid, mw_valid, cp_start}, 0);
    run_case(0, 0, 0, 1000, 1);     // clean pass, start poked while busy (R11)
    run_case(0, 2, 0, 1000, 0);     // two repeats then done (R6)
    run_case(1, 0, 0, 1000, 0);     // bad storage after low half (R5)
    run_case(2, 0, 0, 1000, 0);     // bad storage after high half (R6)
    run_case(0, 100, 0, 1000, 0);   // retry limit reached (R7)
    run_case(0, 0, 1, 50, 0);       // controller never answers (R9)
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end
endmodule